// File: doc/BRIEF.md
# Descriptor Staging and Commit Queue

This block is the entry point through which a host hands transfer descriptors to a DMA engine. The host writes an eight-word descriptor one 32-bit word at a time into a staging register set. The word at index 7 (byte offset 0x1C) is the control word and is written last. Writing it with bit 31 set commits the descriptor: the seven staged words and the control word being written are pushed together into a descriptor queue as one 256-bit entry.

Writes to any other word, or to the control word with bit 31 clear, only update the staging registers and never enqueue anything. A partly written descriptor therefore never reaches the engine. The downstream engine pops whole entries through a valid/ready pair. The block exports full and empty flags, a 16-bit fill level and a sticky flag that records a commit dropped because the queue was full.

Queue occupancy is tracked by a three-state machine. In the `OCC_EMPTY` state the queue holds no entries, in `OCC_PART` it holds some and in `OCC_FULL` it holds `DEPTH` entries. The transitions are:
- `OCC_EMPTY` to `OCC_PART` on an accepted commit.
- `OCC_PART` to `OCC_FULL` on a commit with no pop while the count is `DEPTH-1`.
- `OCC_PART` to `OCC_EMPTY` on a pop with no commit while the count is 1.
- `OCC_FULL` to `OCC_PART` on a pop.

In every other case the state holds.

Top module: `desc_stage_fifo`

## Requirements
- R1: After a synchronous reset, `buf_empty`=1, `buf_full`=0, `fill_level`=0, `desc_valid`=0 and `commit_overflow`=0. All staging words read as zero, so a commit that writes only the control word yields an entry whose words 0 to 6 are zero.
- R2: A write to word index 0 to 6, or to index 7 with bit 31 clear, leaves `fill_level` unchanged. A `desc_ready` while the queue is empty also has no effect.
- R3: A write to index 7 with bit 31 set, made while not full, enqueues one entry, and `fill_level` rises by one after that clock edge. The entry holds staged word i at bits [32i+31:32i] for i = 0 to 6, and the written control word at bits [255:224].
- R4: Entries leave in commit order. `desc_data` shows the oldest entry while `desc_valid` is 1, and a pop happens on a clock edge with `desc_valid` and `desc_ready` both high.
- R5: `fill_level` equals the number of stored entries. `buf_full` is 1 exactly when it equals `DEPTH`, `buf_empty` is 1 exactly when it is 0, and `desc_valid` equals the inverse of `buf_empty`.
- R6: A commit while `buf_full` is 1 is dropped even if a pop happens in the same cycle. The stored entries are unchanged, and `commit_overflow` is set and stays 1 until reset.
- R7: Staging words keep their values after a commit, so a later commit that writes only the control word repeats words 0 to 6.
- R8: A commit and a pop in the same cycle while not full leave `fill_level` unchanged.
- R9: Asserting `rst` mid-run flushes all entries, clears `commit_overflow` and clears the staging words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host word write strobe |
| host_idx | input | 3 | Word index of the write (7 = control) |
| host_data | input | 32 | Write data |
| desc_valid | output | 1 | Queue head is valid |
| desc_ready | input | 1 | Engine accepts the head entry |
| desc_data | output | 256 | Head entry, word i at bits [32i+31:32i] |
| buf_full | output | 1 | Queue holds DEPTH entries |
| buf_empty | output | 1 | Queue holds no entries |
| fill_level | output | 16 | Number of stored entries |
| commit_overflow | output | 1 | Sticky: a commit was dropped while full |

## Verification
Every result is due one clock edge after the write or pop that causes it. `fill_level`, the flags and the overflow bit change on the edge that accepts the write or pop. The head entry becomes visible on `desc_data` from that edge onward. The bench drives each write or pop at a falling edge and compares `desc_data` against its model queue before the rising edge that could pop it. It then checks the level, the flags and the overflow bit 1 ns after that rising edge. The sweep fills the queue to its full depth with a distinct pattern per entry, then drains it.

// File: rtl/dsf_pkg.sv
`timescale 1ns/1ps
package dsf_pkg;
    localparam int WORD_W     = 32;
    localparam int N_WORDS    = 8;
    localparam int IDX_W      = $clog2(N_WORDS);
    localparam int CTL_IDX    = N_WORDS - 1;
    localparam int COMMIT_BIT = WORD_W - 1;
    localparam int DESC_W     = WORD_W * N_WORDS;
    localparam int LEVEL_W    = 16;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_t;
endpackage

// File: rtl/dsf_stage.sv
`timescale 1ns/1ps
module dsf_stage
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    output logic              commit,
    output logic [DESC_W-1:0] entry
);
    logic [WORD_W-1:0] stg [N_WORDS-1];

    for (genvar g = 0; g < N_WORDS - 1; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[g] <= '0;
            end else if (wr && (idx == IDX_W'(g))) begin
                stg[g] <= data;
            end
        end
        assign entry[g*WORD_W +: WORD_W] = stg[g];
    end

    // control word travels live from the bus into the entry
    assign entry[DESC_W-1 -: WORD_W] = data;
    assign commit = wr && (idx == IDX_W'(CTL_IDX)) && data[COMMIT_BIT];
endmodule

// File: rtl/dsf_occ_fsm.sv
`timescale 1ns/1ps
module dsf_occ_fsm
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             full,
    output logic             empty,
    output logic             overflow,
    output logic [CNT_W-1:0] count
);
    occ_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= OCC_EMPTY;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_EMPTY: if (push_ok) state_nx = OCC_PART;
            OCC_PART: begin
                if (push_ok && !pop_ok && count == CNT_W'(DEPTH - 1))
                    state_nx = OCC_FULL;
                else if (pop_ok && !push_ok && count == CNT_W'(1))
                    state_nx = OCC_EMPTY;
            end
            OCC_FULL:  if (pop_ok) state_nx = OCC_PART;
            default:   state_nx = OCC_EMPTY;
        endcase
    end

    always_comb begin
        empty   = (state == OCC_EMPTY);
        full    = (state == OCC_FULL);
        push_ok = push_req && !full;
        pop_ok  = pop_req && !empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
            if (push_req && full)        overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/dsf_queue.sv
`timescale 1ns/1ps
module dsf_queue #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 256,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
        end
    end

    assign rdata = mem[rptr];
endmodule

// File: rtl/desc_stage_fifo.sv
`timescale 1ns/1ps
module desc_stage_fifo
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic [WORD_W-1:0]  host_data,
    output logic               desc_valid,
    input  logic               desc_ready,
    output logic [DESC_W-1:0]  desc_data,
    output logic               buf_full,
    output logic               buf_empty,
    output logic [LEVEL_W-1:0] fill_level,
    output logic               commit_overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              commit, push_ok, pop_ok;
    logic [DESC_W-1:0] entry;
    logic [CNT_W-1:0]  count;

    dsf_stage u_stage (
        .clk(clk), .rst(rst), .wr(host_wr), .idx(host_idx), .data(host_data),
        .commit(commit), .entry(entry)
    );

    dsf_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .push_req(commit), .pop_req(desc_ready),
        .push_ok(push_ok), .pop_ok(pop_ok), .full(buf_full), .empty(buf_empty),
        .overflow(commit_overflow), .count(count)
    );

    dsf_queue #(.DEPTH(DEPTH), .DATA_W(DESC_W)) u_queue (
        .clk(clk), .rst(rst), .push(push_ok), .pop(pop_ok),
        .wdata(entry), .rdata(desc_data)
    );

    assign desc_valid = !buf_empty;
    assign fill_level = LEVEL_W'(count);
endmodule

// File: rtl/desc_stage_fifo_chk.sv
`timescale 1ns/1ps
module desc_stage_fifo_chk
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               host_wr,
    input logic [IDX_W-1:0]   host_idx,
    input logic [WORD_W-1:0]  host_data,
    input logic               desc_valid,
    input logic               desc_ready,
    input logic               buf_full,
    input logic               buf_empty,
    input logic [LEVEL_W-1:0] fill_level,
    input logic               commit_overflow
);
    logic cmt, pop;
    assign cmt = host_wr && (host_idx == IDX_W'(CTL_IDX)) && host_data[COMMIT_BIT];
    assign pop = desc_valid && desc_ready;

    p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LEVEL_W'(DEPTH));
    p_full_flag_r5: assert property (@(posedge clk) disable iff (rst)
        buf_full == (fill_level == LEVEL_W'(DEPTH)));
    p_empty_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (buf_empty == (fill_level == '0)) && (desc_valid == !buf_empty));
    p_no_enqueue_r2: assert property (@(posedge clk) disable iff (rst)
        (!cmt && !pop) |=> $stable(fill_level));
    p_enqueue_r3: assert property (@(posedge clk) disable iff (rst)
        (cmt && !buf_full && !pop) |=> fill_level == LEVEL_W'($past(fill_level) + LEVEL_W'(1)));
    p_dequeue_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !cmt) |=> fill_level == LEVEL_W'($past(fill_level) - LEVEL_W'(1)));
    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (cmt && buf_full && !pop) |=> (commit_overflow && $stable(fill_level)));
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        commit_overflow |=> commit_overflow);
    p_balance_r8: assert property (@(posedge clk) disable iff (rst)
        (cmt && pop && !buf_full) |=> $stable(fill_level));
    p_flush_r9: assert property (@(posedge clk)
        rst |=> (fill_level == '0 && !commit_overflow));
endmodule

bind desc_stage_fifo desc_stage_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_idx(host_idx),
    .host_data(host_data), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .buf_full(buf_full), .buf_empty(buf_empty), .fill_level(fill_level),
    .commit_overflow(commit_overflow)
);

// File: tb/sim_desc_stage_fifo.sv
`timescale 1ns/1ps
module sim_desc_stage_fifo;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_wr = 1'b0;
    logic [2:0]   host_idx = '0;
    logic [31:0]  host_data = '0;
    logic         desc_ready = 1'b0;
    logic         desc_valid, buf_full, buf_empty, commit_overflow;
    logic [255:0] desc_data;
    logic [15:0]  fill_level;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [255:0] mq [$];
    logic [31:0]  sm [7];
    logic         movf = 1'b0;

    always #2.5 clk = ~clk;

    desc_stage_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_idx(host_idx),
        .host_data(host_data), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_data(desc_data), .buf_full(buf_full), .buf_empty(buf_empty),
        .fill_level(fill_level), .commit_overflow(commit_overflow)
    );

    task automatic chk(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int n, input int i);
        return {8'(n) ^ 8'h5A, 8'(i), 16'(n * 257 + i * 4369)};
    endfunction

    task automatic check_flags(input string tag);
        chk(tag, "fill_level", 256'(fill_level), 256'(mq.size()));
        chk(tag, "buf_full", 256'(buf_full), 256'(mq.size() == DEPTH));
        chk(tag, "buf_empty", 256'(buf_empty), 256'(mq.size() == 0));
        chk(tag, "commit_overflow", 256'(commit_overflow), 256'(movf));
    endtask

    task automatic step(input string tag, input logic wr, input int idx,
                        input logic [31:0] data, input logic rdy);
        logic cm, pp, acc;
        logic [255:0] ent;
        @(negedge clk);
        host_wr = wr; host_idx = 3'(idx); host_data = data; desc_ready = rdy;
        if (mq.size() > 0) begin
            chk(tag, "desc_valid", 256'(desc_valid), 256'(1));
            chk(tag, "desc_data", desc_data, mq[0]);
        end else begin
            chk(tag, "desc_valid", 256'(desc_valid), 256'(0));
        end
        cm  = wr && idx == 7 && data[31];
        pp  = rdy && mq.size() > 0;
        acc = cm && mq.size() < DEPTH;
        for (int k = 0; k < 7; k++) ent[k*32 +: 32] = sm[k];
        ent[255:224] = data;
        if (wr && idx < 7) sm[idx] = data;
        @(posedge clk);
        #1;
        if (pp) void'(mq.pop_front());
        if (acc) mq.push_back(ent);
        if (cm && !acc) movf = 1'b1;
        host_wr = 1'b0; desc_ready = 1'b0;
        check_flags(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        mq.delete();
        for (int k = 0; k < 7; k++) sm[k] = '0;
        movf = 1'b0;
        chk(tag, "desc_valid", 256'(desc_valid), 256'(0));
        check_flags(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 7; k++) sm[k] = '0;
        do_reset("R1");
        // R1: commit of control word alone exposes cleared staging words
        step("R1", 1, 7, 32'h8000_00AA, 0);
        step("R1", 0, 0, 0, 1);

        // R2: word writes and uncommitted control writes never enqueue
        for (int i = 0; i < 7; i++) step("R2", 1, i, pat(99, i), 0);
        step("R2", 1, 7, 32'h0000_1234, 0);
        step("R2", 0, 0, 0, 1);

        // R3/R5: fill to depth with distinct descriptors
        for (int n = 0; n < DEPTH; n++) begin
            for (int i = 0; i < 7; i++) step("R5", 1, i, pat(n, i), 0);
            step("R3", 1, 7, 32'h8000_0000 | 32'(n), 0);
        end
        // R6: commits while full are dropped
        step("R6", 1, 7, 32'h8000_0F0F, 0);
        step("R6", 1, 7, 32'h8000_0F10, 0);
        // R4: drain in order
        for (int n = 0; n < DEPTH; n++) step("R4", 0, 0, 0, 1);
        step("R4", 0, 0, 0, 1);

        // R7: staged words persist across commits
        step("R7", 1, 7, 32'h8100_0001, 0);
        step("R7", 1, 7, 32'h8100_0002, 0);
        step("R7", 0, 0, 0, 1);
        step("R7", 0, 0, 0, 1);

        // R8: commit and pop together keep the level
        step("R8", 1, 7, 32'h8200_0000, 0);
        for (int k = 0; k < 6; k++) begin
            step("R8", 1, k, pat(50, k), 0);
            step("R8", 1, 7, 32'h8200_0100 | 32'(k), 1);
        end
        step("R8", 0, 0, 0, 1);

        // R6: commit while full is dropped even with a simultaneous pop
        for (int n = 0; n < DEPTH; n++) begin
            step("R6", 1, n % 7, pat(n + 20, n), 0);
            step("R6", 1, 7, 32'h8300_0000 | 32'(n), 0);
        end
        step("R6", 1, 7, 32'h8300_00FF, 1);
        for (int n = 0; n < DEPTH; n++) step("R6", 0, 0, 0, 1);

        // R9: reset flushes entries, overflow and staging
        for (int n = 0; n < 3; n++) step("R9", 1, 7, 32'h8400_0000 | 32'(n), 0);
        do_reset("R9");
        step("R9", 1, 7, 32'h8000_0055, 0);
        step("R9", 0, 0, 0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule